// File: doc/BRIEF.md
# Decode/Execute Hazard and Stall Arbiter

This block watches the single instruction held in the combined decode/execute stage of a two-stage in-order core. It compares that instruction against the instruction in writeback and decides whether decode/execute has to wait. When it must wait, the block gives one reason. The reasons are: a multi-cycle execution unit is busy, an operand depends on a load that has not returned, or an earlier memory access is still outstanding. The memory reason holds any instruction, so that an error response from that access can still raise a precise interrupt.

When an operand depends on a writeback instruction that is not a load, the block does not stall. Instead it raises a per-operand forward select, so the operand datapath takes the writeback result in place of the register file value. The block also flags a load that immediately follows a store and touches any of the same bytes. All outputs are registered: each one reflects the inputs sampled at the previous rising clock edge.

Top module: `hazard_stall_unit`

## Requirements
- R1: Reset is synchronous and active high. On the edge after reset is sampled high, `stall_o`, `stall_why_o`, `fwd_sel_o` and `mem_raw_o` are all zero.
- R2: Every output is registered, so it shows the result for the inputs present at the previous rising edge. When `id_valid_i` is 0, the next outputs are: no stall, `stall_why_o` = 3'b000 (none), no forwards and no memory read-after-write flag.
- R3: A read-after-write match happens when a used source index equals `wb_rd_i`, the index is nonzero, and `wb_valid_i` and `wb_we_i` are both 1. A match against a writeback load (`wb_is_load_i`=1), for an eligible category, gives `stall_o`=1 with reason LdHz (`stall_why_o`[1]). That operand's forward select stays 0.
- R4: A match against a writeback instruction that is not a load sets that operand's forward select (`fwd_sel_o`[0] for source 1, `fwd_sel_o`[1] for source 2) and causes no stall.
- R5: Source index 0 never produces a match, a forward or a load-hazard stall.
- R6: A source whose use flag (`rs1_used_i` / `rs2_used_i`) is 0 never produces a match, a forward or a load-hazard stall.
- R7: Category codes are 0 ALU, 1 Mul, 2 Div, 3 Branch, 4 Jump, 5 Load, 6 Store, 7 CSR access, and 8 to 15 other/system. A load-hazard stall is raised only for codes 0 to 7.
- R8: When `mc_busy_i` is 1, an Instr stall (`stall_why_o`[0]) is raised only for codes 1 to 4.
- R9: When `mem_pending_i` is 1, a valid instruction of any category gets a Mem stall (`stall_why_o`[2]).
- R10: `stall_why_o` has at most one bit set. The priority is Mem over LdHz over Instr. `stall_o` is 1 exactly when a reason bit is set.
- R11: `mem_raw_o` is 1 when a valid Load (code 5) is in decode/execute and a valid store (`wb_is_store_i`) is in writeback, with equal word addresses and a nonzero AND of the two byte-enable masks. In every other case it is 0.
- R12: When `wb_valid_i` or `wb_we_i` is 0, no match, forward or load-hazard stall arises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Decode/execute holds an instruction |
| id_cat_i | input | 4 | Instruction category code |
| rs1_idx_i | input | REG_W | Source 1 register index |
| rs2_idx_i | input | REG_W | Source 2 register index |
| rs1_used_i | input | 1 | Source 1 is read by the instruction |
| rs2_used_i | input | 1 | Source 2 is read by the instruction |
| id_addr_i | input | ADDR_W | Word address of a decode/execute load |
| id_be_i | input | BE_W | Byte enables of a decode/execute load |
| wb_valid_i | input | 1 | Writeback holds an instruction |
| wb_is_load_i | input | 1 | Writeback instruction is a load |
| wb_is_store_i | input | 1 | Writeback instruction is a store |
| wb_we_i | input | 1 | Writeback writes a register |
| wb_rd_i | input | REG_W | Writeback destination register |
| wb_addr_i | input | ADDR_W | Word address of the writeback store |
| wb_be_i | input | BE_W | Byte enables of the writeback store |
| mem_pending_i | input | 1 | An earlier memory request is outstanding |
| mc_busy_i | input | 1 | A multi-cycle execution unit is busy |
| stall_o | output | 1 | Decode/execute must stall |
| stall_why_o | output | 3 | One-hot reason: [0] Instr, [1] LdHz, [2] Mem; zero means none |
| fwd_sel_o | output | 2 | Per-source forward select from writeback |
| mem_raw_o | output | 1 | Store-to-load byte overlap detected |

## Verification
The assertions assume that the inputs are stable and defined at each rising edge. They also assume that the flags from writeback describe one instruction. The bench keeps to this by changing all inputs together on the falling edge. Random vectors draw register indices from a small range, so that index matches, index-0 cases and byte overlaps happen often. Categories cover the full 4-bit range, so the other/system codes are hit as well. Load and store flags are set independently, which also produces the combined cases that the category masks must filter.

// File: rtl/hsu_pkg.sv
package hsu_pkg;
  localparam int unsigned CAT_W = 4;

  localparam logic [CAT_W-1:0] CAT_ALU    = 4'd0;
  localparam logic [CAT_W-1:0] CAT_MUL    = 4'd1;
  localparam logic [CAT_W-1:0] CAT_DIV    = 4'd2;
  localparam logic [CAT_W-1:0] CAT_BRANCH = 4'd3;
  localparam logic [CAT_W-1:0] CAT_JUMP   = 4'd4;
  localparam logic [CAT_W-1:0] CAT_LOAD   = 4'd5;
  localparam logic [CAT_W-1:0] CAT_STORE  = 4'd6;
  localparam logic [CAT_W-1:0] CAT_CSR    = 4'd7;

  localparam int unsigned WHY_W     = 3;
  localparam int unsigned WHY_INSTR = 0;
  localparam int unsigned WHY_LDHZ  = 1;
  localparam int unsigned WHY_MEM   = 2;

  // categories that read registers and may wait on a load result
  function automatic logic cat_ldhz(input logic [CAT_W-1:0] c);
    return (c <= CAT_CSR);
  endfunction

  // categories that occupy a multi-cycle unit
  function automatic logic cat_multi(input logic [CAT_W-1:0] c);
    return (c >= CAT_MUL) && (c <= CAT_JUMP);
  endfunction
endpackage

// File: rtl/hsu_operand_cmp.sv
module hsu_operand_cmp #(
  parameter int unsigned REG_W = 5
) (
  input  logic             used_i,
  input  logic [REG_W-1:0] idx_i,
  input  logic             wb_writes_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_load_i,
  output logic             raw_o,
  output logic             fwd_o
);
  logic idx_live;

  assign idx_live = used_i && (idx_i != '0);
  assign raw_o    = idx_live && wb_writes_i && (idx_i == wb_rd_i);
  assign fwd_o    = raw_o && !wb_load_i;
endmodule

// File: rtl/hsu_stall_prio.sv
module hsu_stall_prio
  import hsu_pkg::*;
(
  input  logic             mem_i,
  input  logic             ldhz_i,
  input  logic             instr_i,
  output logic [WHY_W-1:0] why_o
);
  always_comb begin
    why_o = '0;
    if (mem_i)        why_o[WHY_MEM]   = 1'b1;
    else if (ldhz_i)  why_o[WHY_LDHZ]  = 1'b1;
    else if (instr_i) why_o[WHY_INSTR] = 1'b1;
  end
endmodule

// File: rtl/hsu_mem_raw.sv
module hsu_mem_raw #(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned BE_W   = 4
) (
  input  logic              ld_i,
  input  logic              st_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [BE_W-1:0]   ld_be_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [BE_W-1:0]   st_be_i,
  output logic              hit_o
);
  logic same_word;
  logic byte_overlap;

  assign same_word    = (ld_addr_i == st_addr_i);
  assign byte_overlap = |(ld_be_i & st_be_i);
  assign hit_o        = ld_i && st_i && same_word && byte_overlap;
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hsu_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid_i,
  input  logic [3:0]        id_cat_i,
  input  logic [REG_W-1:0]  rs1_idx_i,
  input  logic [REG_W-1:0]  rs2_idx_i,
  input  logic              rs1_used_i,
  input  logic              rs2_used_i,
  input  logic [ADDR_W-1:0] id_addr_i,
  input  logic [BE_W-1:0]   id_be_i,
  input  logic              wb_valid_i,
  input  logic              wb_is_load_i,
  input  logic              wb_is_store_i,
  input  logic              wb_we_i,
  input  logic [REG_W-1:0]  wb_rd_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [BE_W-1:0]   wb_be_i,
  input  logic              mem_pending_i,
  input  logic              mc_busy_i,
  output logic              stall_o,
  output logic [2:0]        stall_why_o,
  output logic [1:0]        fwd_sel_o,
  output logic              mem_raw_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] src_idx;
  logic [NUM_SRC-1:0]            src_used;
  logic [NUM_SRC-1:0]            src_raw;
  logic [NUM_SRC-1:0]            src_fwd;
  logic                          wb_writes;
  logic                          ldhz_c, instr_c, mem_c;
  logic [WHY_W-1:0]              why_d;
  logic                          raw_mem_d;

  assign src_idx   = {rs2_idx_i, rs1_idx_i};
  assign src_used  = {rs2_used_i, rs1_used_i};
  assign wb_writes = wb_valid_i && wb_we_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hsu_operand_cmp #(.REG_W(REG_W)) u_cmp (
      .used_i      (src_used[g]),
      .idx_i       (src_idx[g]),
      .wb_writes_i (wb_writes),
      .wb_rd_i     (wb_rd_i),
      .wb_load_i   (wb_is_load_i),
      .raw_o       (src_raw[g]),
      .fwd_o       (src_fwd[g])
    );
  end

  assign ldhz_c  = id_valid_i && cat_ldhz(id_cat_i) && wb_is_load_i && (|src_raw);
  assign instr_c = id_valid_i && cat_multi(id_cat_i) && mc_busy_i;
  assign mem_c   = id_valid_i && mem_pending_i;

  hsu_stall_prio u_prio (
    .mem_i   (mem_c),
    .ldhz_i  (ldhz_c),
    .instr_i (instr_c),
    .why_o   (why_d)
  );

  hsu_mem_raw #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_mraw (
    .ld_i      (id_valid_i && (id_cat_i == CAT_LOAD)),
    .st_i      (wb_valid_i && wb_is_store_i),
    .ld_addr_i (id_addr_i),
    .ld_be_i   (id_be_i),
    .st_addr_i (wb_addr_i),
    .st_be_i   (wb_be_i),
    .hit_o     (raw_mem_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o     <= 1'b0;
      stall_why_o <= '0;
      fwd_sel_o   <= '0;
      mem_raw_o   <= 1'b0;
    end else begin
      stall_o     <= mem_c || ldhz_c || instr_c;
      stall_why_o <= why_d;
      fwd_sel_o   <= id_valid_i ? src_fwd : '0;
      mem_raw_o   <= raw_mem_d;
    end
  end

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !id_valid_i |=> (!stall_o && stall_why_o == '0 && fwd_sel_o == '0 && !mem_raw_o)); // R2
  AST_LOAD_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    wb_is_load_i |=> (fwd_sel_o == '0)); // R3
  AST_X0_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (rs1_idx_i == '0) |=> !fwd_sel_o[0]); // R5
  AST_UNUSED_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    !rs2_used_i |=> !fwd_sel_o[1]); // R6
  AST_SYS_NO_LDHZ: assert property (@(posedge clk) disable iff (rst)
    (id_cat_i > CAT_CSR) |=> !stall_why_o[WHY_LDHZ]); // R7
  AST_MULTI_SCOPE: assert property (@(posedge clk) disable iff (rst)
    (id_cat_i < CAT_MUL || id_cat_i > CAT_JUMP) |=> !stall_why_o[WHY_INSTR]); // R8
  AST_MEM_WINS: assert property (@(posedge clk) disable iff (rst)
    (id_valid_i && mem_pending_i) |=> (stall_why_o == 3'b100)); // R9
  AST_WHY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stall_why_o)); // R10
  AST_STALL_AGREES: assert property (@(posedge clk) disable iff (rst)
    stall_o == (stall_why_o != '0)); // R10
  AST_MRAW_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
    (id_cat_i != CAT_LOAD) |=> !mem_raw_o); // R11
  AST_NO_WRITER_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid_i && wb_we_i) |=> (fwd_sel_o == '0 && !stall_why_o[WHY_LDHZ])); // R12
endmodule

// File: tb/hazard_stall_unit_test.sv
`timescale 1ns/1ps
module hazard_stall_unit_test;
  typedef struct packed {
    logic        idv;
    logic [3:0]  cat;
    logic [4:0]  r1, r2;
    logic        u1, u2;
    logic [29:0] ia;
    logic [3:0]  ib;
    logic        wv, wl, ws, we;
    logic [4:0]  wrd;
    logic [29:0] wa;
    logic [3:0]  wbe;
    logic        mp, mb;
  } vec_t;

  typedef struct packed {
    logic       stall;
    logic [2:0] why;
    logic [1:0] fwd;
    logic       mraw;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  vec_t v;
  logic       stall_o, mem_raw_o;
  logic [2:0] stall_why_o;
  logic [1:0] fwd_sel_o;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  hazard_stall_unit uut (
    .clk(clk), .rst(rst), .id_valid_i(v.idv), .id_cat_i(v.cat),
    .rs1_idx_i(v.r1), .rs2_idx_i(v.r2), .rs1_used_i(v.u1), .rs2_used_i(v.u2),
    .id_addr_i(v.ia), .id_be_i(v.ib), .wb_valid_i(v.wv), .wb_is_load_i(v.wl),
    .wb_is_store_i(v.ws), .wb_we_i(v.we), .wb_rd_i(v.wrd), .wb_addr_i(v.wa),
    .wb_be_i(v.wbe), .mem_pending_i(v.mp), .mc_busy_i(v.mb),
    .stall_o(stall_o), .stall_why_o(stall_why_o), .fwd_sel_o(fwd_sel_o),
    .mem_raw_o(mem_raw_o)
  );

  function automatic exp_t model(input vec_t x);
    exp_t e;
    logic m1, m2, ld, ins, mem;
    m1  = x.u1 && x.r1 != 0 && x.wv && x.we && x.r1 == x.wrd;
    m2  = x.u2 && x.r2 != 0 && x.wv && x.we && x.r2 == x.wrd;
    ld  = x.idv && x.cat <= 7 && x.wl && (m1 || m2);
    ins = x.idv && x.cat >= 1 && x.cat <= 4 && x.mb;
    mem = x.idv && x.mp;
    e.why   = mem ? 3'b100 : ld ? 3'b010 : ins ? 3'b001 : 3'b000;
    e.stall = mem || ld || ins;
    e.fwd   = x.idv ? {m2 && !x.wl, m1 && !x.wl} : 2'b00;
    e.mraw  = x.idv && x.cat == 5 && x.wv && x.ws && x.ia == x.wa && (x.ib & x.wbe) != 0;
    return e;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic apply(input vec_t x, input string tag);
    exp_t e;
    v = x;
    e = model(x);
    @(negedge clk);
    check(tag, "stall", stall_o, e.stall);
    check(tag, "why", stall_why_o, e.why);
    check(tag, "fwd", fwd_sel_o, e.fwd);
    check(tag, "mem_raw", mem_raw_o, e.mraw);
  endtask

  function automatic string tag_of(input vec_t x);
    exp_t e = model(x);
    if (e.why[2]) return "R9";
    if (e.why[1]) return "R3";
    if (e.why[0]) return "R8";
    if (e.fwd != 0) return "R4";
    if (e.mraw) return "R11";
    return "R10";
  endfunction

  function automatic vec_t base();
    vec_t x = '0;
    x.idv = 1'b1; x.u1 = 1'b1; x.u2 = 1'b1; x.wv = 1'b1; x.we = 1'b1;
    return x;
  endfunction

  initial begin
    #(5ns * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual expired expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t x;
    void'($urandom(32'd1234));
    v = '0;
    v.idv = 1'b1; v.mp = 1'b1; v.mb = 1'b1; v.cat = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "stall", stall_o, 0);
    check("R1", "why", stall_why_o, 0);
    check("R1", "fwd", fwd_sel_o, 0);
    check("R1", "mem_raw", mem_raw_o, 0);
    rst = 1'b0;

    // empty stage with every cause asserted
    x = base(); x.idv = 0; x.mp = 1; x.mb = 1; x.wl = 1; x.r1 = 3; x.wrd = 3; x.cat = 1;
    apply(x, "R2");
    // load hazard on source 1
    x = base(); x.r1 = 4; x.wrd = 4; x.wl = 1; apply(x, "R3");
    // forward source 2 from a non-load
    x = base(); x.r2 = 7; x.wrd = 7; apply(x, "R4");
    x = base(); x.r1 = 9; x.r2 = 9; x.wrd = 9; x.cat = 6; apply(x, "R4");
    // register zero
    x = base(); x.r1 = 0; x.wrd = 0; apply(x, "R5");
    x = base(); x.r2 = 0; x.wrd = 0; x.wl = 1; apply(x, "R5");
    // unused operand
    x = base(); x.u2 = 0; x.r2 = 6; x.wrd = 6; x.wl = 1; apply(x, "R6");
    x = base(); x.u1 = 0; x.r1 = 6; x.wrd = 6; apply(x, "R6");
    // other/system category ignores a load hazard
    x = base(); x.cat = 9; x.r1 = 5; x.wrd = 5; x.wl = 1; apply(x, "R7");
    x = base(); x.cat = 7; x.r1 = 5; x.wrd = 5; x.wl = 1; apply(x, "R7");
    // multi-cycle stall scope
    x = base(); x.cat = 2; x.mb = 1; apply(x, "R8");
    x = base(); x.cat = 0; x.mb = 1; apply(x, "R8");
    x = base(); x.cat = 5; x.mb = 1; apply(x, "R8");
    // memory stall holds any category
    x = base(); x.cat = 12; x.mp = 1; apply(x, "R9");
    // priority
    x = base(); x.cat = 1; x.mp = 1; x.mb = 1; x.wl = 1; x.r1 = 2; x.wrd = 2; apply(x, "R10");
    x = base(); x.cat = 3; x.mb = 1; x.wl = 1; x.r2 = 2; x.wrd = 2; apply(x, "R10");
    // store then overlapping load
    x = base(); x.cat = 5; x.ws = 1; x.we = 0; x.ia = 30'h10; x.wa = 30'h10; x.ib = 4'b0011; x.wbe = 4'b0010;
    apply(x, "R11");
    x.wbe = 4'b1100; apply(x, "R11");
    x.wbe = 4'b0010; x.wa = 30'h11; apply(x, "R11");
    x.wa = 30'h10; x.cat = 6; apply(x, "R11");
    // no writer in writeback
    x = base(); x.we = 0; x.r1 = 8; x.wrd = 8; x.wl = 1; apply(x, "R12");
    x = base(); x.wv = 0; x.r2 = 8; x.wrd = 8; apply(x, "R12");

    for (int i = 0; i < 3000; i++) begin
      x.idv = ($urandom % 8) != 0;
      x.cat = 4'($urandom);
      x.r1 = 5'($urandom % 4); x.r2 = 5'($urandom % 4);
      x.u1 = 1'($urandom); x.u2 = 1'($urandom);
      x.ia = 30'($urandom % 3); x.ib = 4'($urandom);
      x.wv = 1'($urandom); x.wl = 1'($urandom); x.ws = 1'($urandom); x.we = 1'($urandom);
      x.wrd = 5'($urandom % 4); x.wa = 30'($urandom % 3); x.wbe = 4'($urandom);
      x.mp = ($urandom % 4) == 0; x.mb = 1'($urandom);
      apply(x, tag_of(x));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule